// File: doc/BRIEF.md
# Block I/O Repeat Transfer Sequencer

This block steps a processor core through a repeating block I/O instruction, one T-state per clock. It handles two directions. In the first, bytes move from an I/O port into memory. In the second, bytes move from memory out to the port. The port number comes from a port register, and the memory side uses a 16-bit pointer. After every byte, the pointer and an 8-bit remaining-count register each drop by one, so the transfer walks from high addresses to low ones.

Each iteration has four or five machine cycles. During them the block drives the memory request, I/O request, read, write and refresh strobes, along with the address bus. Between two iterations there is a window in which a pending interrupt can stop the loop. When that happens, the program counter is left at the prefix byte, so the instruction later resumes with the updated pointer and count.

Top module: `blkio_rpt_seq`

## Requirements
- R1: A start pulse is accepted only while idle, and only with prefix 0xED followed by 0xBA (port to memory) or 0xBB (memory to port). Any other byte pair leaves busy low and all strobes low.
- R2: Every iteration moves exactly one byte. At the end of its fourth machine cycle, ptr and cnt each fall by one.
- R3: cnt is tested for zero after it is decremented, so a starting count of 0 runs 256 iterations and finishes with ptr equal to the start value minus 256.
- R4: An iteration that leaves cnt nonzero lasts 21 T-states (machine cycles of 4, 5, 3, 4 and 5). The last iteration lasts 16 T-states (4, 5, 3, 4). For a count n, busy is high for exactly 21(n-1)+16 clocks.
- R5: In machine cycles 1 and 2, T-states 1–2 assert mreq and rd, with addr set to pc_init and pc_init+1 respectively. T-states 3–4 of those cycles assert rfsh with addr 0.
- R6: The I/O access puts the port register on addr[7:0] and the current cnt on addr[15:8]. The memory access puts ptr on addr. mreq and iorq are never high together.
- R7: For 0xBA, machine cycle 3 reads the port (iorq, rd, T-states 1–2), and machine cycle 4 writes that byte to memory (mreq, wr, T-states 1–3). For 0xBB, machine cycle 3 reads memory and machine cycle 4 writes the byte to the port. Outside strobed T-states, addr is 0.
- R8: On completion, done pulses for one clock with busy low, flag_z and flag_n are 1, and pc_out equals pc_init+2.
- R9: When int_req is high at the last T-state of machine cycle 5, the loop stops. int_take then pulses for one clock, pc_out equals pc_init, flag_z is 0, and ptr and cnt keep their decremented values.
- R10: After reset, busy, done, int_take, every strobe, the flags, ptr, cnt and pc_out are all 0.
- R11: A start pulse that arrives while busy is ignored, and the running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin the instruction |
| op_prefix | input | 8 | First opcode byte |
| op_code | input | 8 | Second opcode byte |
| ptr_init | input | 16 | Starting memory pointer |
| cnt_init | input | 8 | Starting byte count (0 means 256) |
| port_init | input | 8 | Port number |
| pc_init | input | 16 | Address of the prefix byte |
| int_req | input | 1 | Pending interrupt |
| mem_rdata | input | 8 | Memory read data |
| io_rdata | input | 8 | Port read data |
| addr | output | 16 | Address bus |
| mreq | output | 1 | Memory request strobe |
| iorq | output | 1 | I/O request strobe |
| rd | output | 1 | Read strobe |
| wr | output | 1 | Write strobe |
| rfsh | output | 1 | Refresh strobe |
| wdata | output | 8 | Write data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-clock completion pulse |
| int_take | output | 1 | One-clock pulse when the loop stops for an interrupt |
| pc_out | output | 16 | Program counter left by the instruction |
| ptr | output | 16 | Current memory pointer |
| cnt | output | 8 | Current remaining count |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Subtract flag |

## Verification
Once a start is accepted, the first T-state of machine cycle 1 appears on the outputs in the next clock, and each later T-state follows one clock after the one before. The bench's reference model expands every run into a per-clock list of expected strobes, addresses and write bytes, and compares the outputs at each falling edge. The end-of-run results (done or int_take, flags, pc_out, ptr, cnt) are due one clock after the last listed T-state and are sampled exactly there. A single clock after that, done must already be low again.

// File: rtl/blkio_rpt_seq.sv
module blkio_rpt_seq #(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DW-1:0]     op_prefix,
  input  logic [DW-1:0]     op_code,
  input  logic [2*DW-1:0]   ptr_init,
  input  logic [DW-1:0]     cnt_init,
  input  logic [DW-1:0]     port_init,
  input  logic [2*DW-1:0]   pc_init,
  input  logic              int_req,
  input  logic [DW-1:0]     mem_rdata,
  input  logic [DW-1:0]     io_rdata,
  output logic [2*DW-1:0]   addr,
  output logic              mreq,
  output logic              iorq,
  output logic              rd,
  output logic              wr,
  output logic              rfsh,
  output logic [DW-1:0]     wdata,
  output logic              busy,
  output logic              done,
  output logic              int_take,
  output logic [2*DW-1:0]   pc_out,
  output logic [2*DW-1:0]   ptr,
  output logic [DW-1:0]     cnt,
  output logic              flag_z,
  output logic              flag_n
);
  localparam int AW = 2 * DW;
  localparam logic [DW-1:0] PFX    = DW'(8'hED);
  localparam logic [DW-1:0] OP_IN  = DW'(8'hBA);
  localparam logic [DW-1:0] OP_OUT = DW'(8'hBB);

  logic          act, din;
  logic [2:0]    mc, t, mlen;
  logic [DW-1:0] port, dlat;
  logic [AW-1:0] pc;

  always_comb begin
    case (mc)
      3'd0:    mlen = 3'd4;
      3'd1:    mlen = 3'd5;
      3'd2:    mlen = 3'd3;
      3'd3:    mlen = 3'd4;
      default: mlen = 3'd5;
    endcase
  end

  wire last_t   = (t == mlen - 3'd1);
  wire fetch_on = act && (mc < 3'd2) && (t < 3'd2);
  wire rfsh_on  = act && (mc < 3'd2) && (t == 3'd2 || t == 3'd3);
  wire rd_on    = act && (mc == 3'd2) && (t < 3'd2);
  wire wr_on    = act && (mc == 3'd3) && (t < 3'd3);
  wire io_on    = (rd_on && din) || (wr_on && !din);
  wire mem_on   = (rd_on && !din) || (wr_on && din);
  wire ok_op    = (op_prefix == PFX) && (op_code == OP_IN || op_code == OP_OUT);

  assign mreq  = fetch_on || mem_on;
  assign iorq  = io_on;
  assign rd    = fetch_on || rd_on;
  assign wr    = wr_on;
  assign rfsh  = rfsh_on;
  assign busy  = act;
  assign wdata = dlat;
  assign addr  = fetch_on ? ((mc == 3'd0) ? pc : pc + AW'(1)) :
                 mem_on   ? ptr :
                 io_on    ? {cnt, port} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0; din <= 1'b0; mc <= '0; t <= '0;
      port <= '0; dlat <= '0; pc <= '0; pc_out <= '0;
      ptr <= '0; cnt <= '0; flag_z <= 1'b0; flag_n <= 1'b0;
      done <= 1'b0; int_take <= 1'b0;
    end else begin
      done     <= 1'b0;
      int_take <= 1'b0;
      if (!act) begin
        if (start && ok_op) begin
          act  <= 1'b1;
          din  <= (op_code == OP_IN);
          mc   <= '0;
          t    <= '0;
          ptr  <= ptr_init;
          cnt  <= cnt_init;
          port <= port_init;
          pc   <= pc_init;
        end
      end else begin
        if (rd_on && t == 3'd1)
          dlat <= din ? io_rdata : mem_rdata;
        if (!last_t) begin
          t <= t + 3'd1;
        end else begin
          t <= '0;
          if (mc == 3'd3) begin
            ptr    <= ptr - AW'(1);
            cnt    <= cnt - DW'(1);
            flag_n <= 1'b1;
            flag_z <= (cnt == DW'(1));
            if (cnt == DW'(1)) begin
              act    <= 1'b0;
              done   <= 1'b1;
              pc_out <= pc + AW'(2);
            end else begin
              mc <= 3'd4;
            end
          end else if (mc == 3'd4) begin
            if (int_req) begin
              act      <= 1'b0;
              int_take <= 1'b1;
              pc_out   <= pc;
            end else begin
              mc <= 3'd0;
            end
          end else begin
            mc <= mc + 3'd1;
          end
        end
      end
    end
  end

  assert_one_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mreq && iorq));
  assert_write_targets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (mreq != iorq) && !rd);
  assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mreq || iorq || rd || wr || rfsh));
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && cnt != $past(cnt)) |-> cnt == $past(cnt) - DW'(1));
  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && ptr != $past(ptr)) |-> ptr == $past(ptr) - AW'(1));
  assert_done_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && flag_z && flag_n && cnt == '0);
  assert_take_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int_take |-> !busy && !flag_z && !done);
  assert_pulse_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_blkio_rpt_seq.sv
module tb_blkio_rpt_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        start = 1'b0;
  logic [7:0]  op_prefix = 8'h00, op_code = 8'h00;
  logic [15:0] ptr_init = '0, pc_init = '0;
  logic [7:0]  cnt_init = '0, port_init = '0;
  logic        int_req = 1'b0;
  logic [7:0]  mem_rdata, io_rdata;
  logic [15:0] addr, pc_out, ptr;
  logic        mreq, iorq, rd, wr, rfsh, busy, done, int_take, flag_z, flag_n;
  logic [7:0]  wdata, cnt;

  int total = 0;
  int bad = 0;

  function automatic logic [7:0] mfn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] ifn(input logic [15:0] a);
    return (a[15:8] * 8'd7) ^ a[7:0] ^ 8'hC3;
  endfunction

  function automatic logic [28:0] rec(input logic [4:0] s, input logic [15:0] a, input logic [7:0] w);
    return {s, a, w};
  endfunction

  assign mem_rdata = mfn(addr);
  assign io_rdata  = ifn(addr);

  blkio_rpt_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_prefix(op_prefix), .op_code(op_code),
    .ptr_init(ptr_init), .cnt_init(cnt_init), .port_init(port_init), .pc_init(pc_init),
    .int_req(int_req), .mem_rdata(mem_rdata), .io_rdata(io_rdata), .addr(addr),
    .mreq(mreq), .iorq(iorq), .rd(rd), .wr(wr), .rfsh(rfsh), .wdata(wdata),
    .busy(busy), .done(done), .int_take(int_take), .pc_out(pc_out), .ptr(ptr),
    .cnt(cnt), .flag_z(flag_z), .flag_n(flag_n)
  );

  task automatic chk(input bit ok, input string req, input longint act_v, input longint exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic run(input logic [7:0] code, input logic [15:0] p0, input logic [7:0] c0,
                     input logic [7:0] pt, input logic [15:0] pc0, input bit irq, input bit hold);
    logic [28:0] q[$];
    int n, iters, nbusy;
    bit din;
    n = (c0 == 8'd0) ? 256 : int'(c0);
    din = (code == 8'hBA);
    iters = n;
    for (int k = 0; k < n; k++) begin
      logic [7:0]  cc;
      logic [15:0] p, ioa;
      logic [7:0]  b;
      cc = c0 - 8'(k);
      p = p0 - 16'(k);
      ioa = {cc, pt};
      for (int m = 0; m < 2; m++) begin
        q.push_back(rec(5'b10100, pc0 + 16'(m), 8'h00));
        q.push_back(rec(5'b10100, pc0 + 16'(m), 8'h00));
        q.push_back(rec(5'b00001, 16'h0000, 8'h00));
        q.push_back(rec(5'b00001, 16'h0000, 8'h00));
        if (m == 1) q.push_back(rec(5'b00000, 16'h0000, 8'h00));
      end
      b = din ? ifn(ioa) : mfn(p);
      for (int j = 0; j < 2; j++)
        q.push_back(din ? rec(5'b01100, ioa, 8'h00) : rec(5'b10100, p, 8'h00));
      q.push_back(rec(5'b00000, 16'h0000, 8'h00));
      for (int j = 0; j < 3; j++)
        q.push_back(din ? rec(5'b10010, p, b) : rec(5'b01010, ioa, b));
      q.push_back(rec(5'b00000, 16'h0000, 8'h00));
      if (k == n - 1) break;
      for (int j = 0; j < 5; j++) q.push_back(rec(5'b00000, 16'h0000, 8'h00));
      if (irq) begin
        iters = k + 1;
        break;
      end
    end

    @(negedge clk);
    op_prefix = 8'hED; op_code = code; ptr_init = p0; cnt_init = c0;
    port_init = pt; pc_init = pc0; int_req = irq; start = 1'b1;
    nbusy = 0;
    for (int i = 0; i < q.size(); i++) begin
      logic [4:0] s;
      @(negedge clk);
      if (i == 0 && !hold) start = 1'b0;
      if (i == 0 && hold) begin
        ptr_init = 16'hBEEF; cnt_init = 8'h07; op_code = 8'hBA;
      end
      if (hold && i == q.size() - 2) start = 1'b0;
      if (busy) nbusy++;
      s = {mreq, iorq, rd, wr, rfsh};
      chk(s == q[i][28:24], "R5 R6 R7 R11 strobes", s, q[i][28:24]);
      chk(addr == q[i][23:8], "R5 R6 R7 R11 addr", addr, q[i][23:8]);
      if (q[i][25]) chk(wdata == q[i][7:0], "R2 R7 wdata", wdata, q[i][7:0]);
    end
    chk(nbusy == q.size(), "R4 busy length", nbusy, q.size());
    @(negedge clk);
    chk(!busy, "R4 busy low after last T-state", busy, 0);
    chk(ptr == p0 - 16'(iters), "R2 R3 final ptr", ptr, p0 - 16'(iters));
    chk(cnt == c0 - 8'(iters), "R2 R3 final cnt", cnt, c0 - 8'(iters));
    if (iters < n) begin
      chk(int_take && !done, "R9 int_take pulse", {int_take, done}, 2'b10);
      chk(pc_out == pc0, "R9 pc back at prefix", pc_out, pc0);
      chk(!flag_z && flag_n, "R9 flags", {flag_z, flag_n}, 2'b01);
    end else begin
      chk(done && !int_take, "R8 done pulse", {done, int_take}, 2'b10);
      chk(pc_out == pc0 + 16'd2, "R8 pc past instruction", pc_out, pc0 + 16'd2);
      chk(flag_z && flag_n, "R8 flags", {flag_z, flag_n}, 2'b11);
    end
    int_req = 1'b0;
    @(negedge clk);
    chk(!done && !int_take, "R8 R9 single-clock pulse", {done, int_take}, 0);
  endtask

  task automatic try_bad(input logic [7:0] pf, input logic [7:0] cd);
    logic [15:0] p_before;
    p_before = ptr;
    @(negedge clk);
    op_prefix = pf; op_code = cd; ptr_init = 16'h4444; cnt_init = 8'h05; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(!busy && !(mreq || iorq || rd || wr || rfsh), "R1 rejected opcode stays idle",
          {busy, mreq, iorq, rd, wr, rfsh}, 0);
      @(negedge clk);
    end
    chk(ptr == p_before, "R1 rejected opcode leaves ptr", ptr, p_before);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy, done, int_take, mreq, iorq, rd, wr, rfsh, flag_z, flag_n} == 0,
        "R10 reset controls", {busy, done, int_take, mreq, iorq, rd, wr, rfsh, flag_z, flag_n}, 0);
    chk(ptr == 0 && cnt == 0 && pc_out == 0, "R10 reset registers", {ptr, cnt, pc_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    try_bad(8'hED, 8'hBC);
    try_bad(8'hDD, 8'hBA);

    run(8'hBA, 16'h8010, 8'd1, 8'h3C, 16'h0100, 1'b0, 1'b0);
    run(8'hBB, 16'h20FF, 8'd3, 8'h81, 16'h0200, 1'b0, 1'b0);
    run(8'hBA, 16'h9000, 8'd0, 8'h55, 16'h0300, 1'b0, 1'b0);
    run(8'hBB, 16'h7000, 8'd3, 8'h12, 16'h0400, 1'b1, 1'b0);
    run(8'hBB, ptr, cnt, 8'h12, 16'h0400, 1'b0, 1'b0);
    run(8'hBB, 16'h0001, 8'd3, 8'hA7, 16'hFFFE, 1'b0, 1'b1);

    summary();
    $finish;
  end
endmodule